// File: doc/BRIEF.md
# Clock-Synchronous Byte Serial Port

This block moves one byte at a time over a three-wire synchronous link: a shift clock, a data-in line and a data-out line. A single shift register of `W` bits does both jobs. It shifts received bits in from `sin` while it shifts the loaded byte out on `sout`. As master, the port makes the shift clock itself from one of seven divided clock enables that arrive on `tick_en`. As slave, it follows a clock driven by another device on `sclk_i`. The slave clock is brought into the system clock domain through a synchronizer.

Software sets the port up through plain control inputs: port enable, data-out enable, clock source, clock format, bit order and the role of a shared handshake pin. Software then loads a byte and pulses `trig`. When the byte is complete the port latches the received data and raises a one-cycle interrupt pulse. The shared pin can be a ready output, which tells an external master that the slave is armed. It can instead be an active-low select input, which gates a slave transfer.

The byte to send enters through a valid/ready pair. `tx_ready` is high exactly while no transfer is in progress, and a byte is taken on any cycle where `tx_valid` and `tx_ready` are both high. A source that keeps `tx_valid` high simply waits for `tx_ready`. If `tx_valid` is high on a cycle where `tx_ready` is low, that cycle is not a transfer, and the shift register keeps the byte that is being sent. Received data has no back-pressure: `rx_data` holds the last completed byte until the next completion overwrites it.

Top module: `sio_port`

## Requirements
- R1: After reset, `busy`, `irq`, `sclk_oe`, `sout_oe` and `ss_rdy_oe` are 0, `rx_data` is 0 and `tx_ready` is 1.
- R2: With `clk_sel` in 0..6, each `tick_en[clk_sel]` pulse during a transfer toggles `sclk_o`. A byte takes exactly 16 toggles, and `sclk_o` does not toggle outside a transfer.
- R3: `sclk_oe` is 1 exactly when `en` is 1 and `clk_sel` is not 7. While no transfer runs, `sclk_o` rests at the idle level `fmt[1]`.
- R4: `sout_oe` is 1 only when both `en` and `dout_en` are 1. Select mode can also hold it at 0 (see R10).
- R5: `fmt[1]` is the clock idle level. The leading edge is the edge that moves the clock away from idle. With `fmt[0]=0`, data is sampled on the leading edge and `sout` changes on the trailing edge. With `fmt[0]=1`, `sout` changes on the leading edge and data is sampled on the trailing edge. The first bit is on `sout` from the cycle after the trigger.
- R6: With `lsb_first=0`, bit 7 is sent and received first. With `lsb_first=1`, bit 0 goes first. `rx_data` always holds the received byte at its natural bit weights.
- R7: On the cycle after the last clock edge of a byte, `busy` is 0. On the cycle after that, `irq` is high for exactly one cycle and `rx_data` shows the received byte.
- R8: With `clk_sel=7` (slave), transitions on `sclk_i` drive the shift after synchronization. They are counted only while `busy` is 1.
- R9: In slave mode with `pin_fn_en=1` and `rdy_sel=1`, `ss_rdy_oe` is 1. `ss_rdy_o` goes to 1 after the trigger and falls on the first clock edge of the byte. In any other mode `ss_rdy_oe` is 0.
- R10: In slave mode with `pin_fn_en=1` and `rdy_sel=0`, a high `ss_rdy_i` makes the port ignore clock edges, resets its edge count and forces `sout_oe` to 0.
- R11: `tx_ready` equals the inverse of `busy`. An accepted write loads the shift register, and a write offered while busy does not change the byte being sent.
- R12: `trig` starts a transfer only when `en` is 1 and `busy` is 0. Dropping `en` clears `busy` on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Port enable |
| dout_en | input | 1 | Data-out drive enable |
| trig | input | 1 | Start-transfer pulse |
| clk_sel | input | SEL_W | Clock source: 0..6 internal, 7 slave |
| fmt | input | 2 | [1] idle level, [0] sample on trailing edge |
| lsb_first | input | 1 | Bit order select |
| pin_fn_en | input | 1 | Enables the shared pin function |
| rdy_sel | input | 1 | Shared pin: 1 ready output, 0 select input |
| tick_en | input | N_SRC | Divided clock enables for master mode |
| tx_valid | input | 1 | Transmit byte valid |
| tx_ready | output | 1 | Port can accept a transmit byte |
| tx_data | input | W | Transmit byte |
| rx_data | output | W | Last received byte |
| irq | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Transfer in progress |
| sclk_i | input | 1 | Shift clock from external master |
| sclk_o | output | 1 | Shift clock driven in master mode |
| sclk_oe | output | 1 | Shift clock drive enable |
| sin | input | 1 | Serial data in |
| sout | output | 1 | Serial data out |
| sout_oe | output | 1 | Serial data out drive enable |
| ss_rdy_i | input | 1 | Active-low select input |
| ss_rdy_o | output | 1 | Ready output, active high |
| ss_rdy_oe | output | 1 | Ready output drive enable |

## Verification
The bench sweeps every internal clock source against all four clock formats and both bit orders. It watches `sclk_o` and `sout` to rebuild the byte on the wire, and it feeds a separate pattern into `sin`. A swapped sample/launch edge or a reversed shift direction would therefore corrupt one of the two bytes. An off-by-one edge count would show up as 15 or 17 clock toggles, or as a received byte shifted by one place. In slave mode the bench drives the clock itself, checks that the ready pin falls on the first edge, and holds the select input high across several edges. A port that still counted those edges would finish early or with corrupted data. A write offered in the middle of a byte must not reach the wire, and a trigger given while the port is disabled must not start a transfer.

// File: rtl/sio_pkg.sv
package sio_pkg;
  // One shift-clock event as seen by the transfer control.
  typedef struct packed {
    logic ev;    // a clock edge happened this cycle
    logic lead;  // that edge moved the clock away from its idle level
  } sio_edge_t;
endpackage

// File: rtl/sio_mclk.sv
module sio_mclk
  import sio_pkg::*;
#(
  parameter int N_SRC = 7,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             run,
  input  logic             cpol,
  input  logic [SEL_W-1:0] sel,
  input  logic [N_SRC-1:0] tick_en,
  output sio_edge_t        ev_o,
  output logic             sclk_o
);
  localparam int NPAD = 1 << SEL_W;

  logic [NPAD-1:0] tick_pad;
  logic            tick;
  logic            sclk_q;

  // Codes above the internal sources select no tick.
  always_comb begin
    tick_pad = '0;
    for (int i = 0; i < N_SRC; i++) tick_pad[i] = tick_en[i];
  end
  assign tick = tick_pad[sel];

  // The clock rests at the idle level and toggles on each tick while running.
  always_ff @(posedge clk) begin
    if (!run)      sclk_q <= cpol;
    else if (tick) sclk_q <= ~sclk_q;
  end

  assign ev_o.ev   = run && tick;
  assign ev_o.lead = (sclk_q == cpol);
  assign sclk_o    = sclk_q;
endmodule

// File: rtl/sio_sclk_sync.sv
module sio_sclk_sync
  import sio_pkg::*;
#(
  parameter int STAGES = 3
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sclk_i,
  input  logic      cpol,
  output sio_edge_t ev_o
);
  logic [STAGES-1:0] sy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sy <= '0;
    else        sy <= {sy[STAGES-2:0], sclk_i};
  end

  // A change between the last two stages is one clock edge.
  assign ev_o.ev   = sy[STAGES-2] ^ sy[STAGES-1];
  assign ev_o.lead = (sy[STAGES-2] != cpol);
endmodule

// File: rtl/sio_shifter.sv
module sio_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         arm,
  input  logic         lsb_first,
  input  logic         sample,
  input  logic         launch,
  input  logic         sin,
  output logic [W-1:0] sr,
  output logic         sout_bit
);
  logic [W-1:0] arm_src;
  logic         obit;

  assign arm_src = load ? load_data : sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr   <= '0;
      obit <= 1'b0;
    end else begin
      if (load)
        sr <= load_data;
      else if (sample)
        sr <= lsb_first ? {sin, sr[W-1:1]} : {sr[W-2:0], sin};

      if (arm)
        obit <= lsb_first ? arm_src[0] : arm_src[W-1];
      else if (launch)
        obit <= lsb_first ? sr[0] : sr[W-1];
    end
  end

  assign sout_bit = obit;
endmodule

// File: rtl/sio_port.sv
module sio_port
  import sio_pkg::*;
#(
  parameter  int W     = 8,
  parameter  int N_SRC = 7,
  localparam int SEL_W = $clog2(N_SRC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             dout_en,
  input  logic             trig,
  input  logic [SEL_W-1:0] clk_sel,
  input  logic [1:0]       fmt,
  input  logic             lsb_first,
  input  logic             pin_fn_en,
  input  logic             rdy_sel,
  input  logic [N_SRC-1:0] tick_en,
  input  logic             tx_valid,
  output logic             tx_ready,
  input  logic [W-1:0]     tx_data,
  output logic [W-1:0]     rx_data,
  output logic             irq,
  output logic             busy,
  input  logic             sclk_i,
  output logic             sclk_o,
  output logic             sclk_oe,
  input  logic             sin,
  output logic             sout,
  output logic             sout_oe,
  input  logic             ss_rdy_i,
  output logic             ss_rdy_o,
  output logic             ss_rdy_oe
);
  localparam int             ECW       = $clog2(2 * W);
  localparam logic [ECW-1:0] LAST_EDGE = ECW'(2 * W - 1);
  localparam logic [SEL_W-1:0] SLAVE_CODE = SEL_W'(N_SRC);

  sio_edge_t      m_ev, s_ev;
  logic           master, cpol, cpha;
  logic           ss_mode, ss_block, rdy_mode;
  logic [1:0]     ss_sy;
  logic           busy_q, rdy_q, done_q, irq_q;
  logic [ECW-1:0] ecnt;
  logic           ev, lead, sample, launch, start, load, done_ev;
  logic [W-1:0]   sr;
  logic [W-1:0]   rx_q;
  logic           sout_bit;

  assign master   = (clk_sel != SLAVE_CODE);
  assign cpol     = fmt[1];
  assign cpha     = fmt[0];
  assign ss_mode  = !master && pin_fn_en && !rdy_sel;
  assign rdy_mode = !master && pin_fn_en && rdy_sel;
  assign ss_block = ss_mode && ss_sy[1];

  sio_mclk #(.N_SRC(N_SRC), .SEL_W(SEL_W)) u_mclk (
    .clk     (clk),
    .run     (busy_q && master),
    .cpol    (cpol),
    .sel     (clk_sel),
    .tick_en (tick_en),
    .ev_o    (m_ev),
    .sclk_o  (sclk_o)
  );

  sio_sclk_sync #(.STAGES(3)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .sclk_i (sclk_i),
    .cpol   (cpol),
    .ev_o   (s_ev)
  );

  // The select input idles inactive (high) out of reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ss_sy <= 2'b11;
    else        ss_sy <= {ss_sy[0], ss_rdy_i};
  end

  assign ev      = master ? m_ev.ev : (s_ev.ev && busy_q && !ss_block);
  assign lead    = master ? m_ev.lead : s_ev.lead;
  assign sample  = ev && (lead != cpha);
  assign launch  = ev && (lead == cpha);
  assign start   = en && trig && !busy_q;
  assign load    = tx_valid && !busy_q;
  assign done_ev = ev && (ecnt == LAST_EDGE);

  sio_shifter #(.W(W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .load_data (tx_data),
    .arm       (start),
    .lsb_first (lsb_first),
    .sample    (sample),
    .launch    (launch),
    .sin       (sin),
    .sr        (sr),
    .sout_bit  (sout_bit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      rdy_q  <= 1'b0;
      ecnt   <= '0;
    end else if (!en) begin
      busy_q <= 1'b0;
      rdy_q  <= 1'b0;
      ecnt   <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      rdy_q  <= !master;
      ecnt   <= '0;
    end else if (ss_block) begin
      ecnt   <= '0;
    end else if (ev) begin
      rdy_q  <= 1'b0;
      ecnt   <= ecnt + ECW'(1);
      if (done_ev) busy_q <= 1'b0;
    end
  end

  // Completion is seen one cycle after the final edge so the last shift lands first.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      irq_q  <= 1'b0;
      rx_q   <= '0;
    end else begin
      done_q <= done_ev;
      irq_q  <= done_q;
      if (done_q) rx_q <= sr;
    end
  end

  assign busy      = busy_q;
  assign tx_ready  = !busy_q;
  assign irq       = irq_q;
  assign rx_data   = rx_q;
  assign sclk_oe   = en && master;
  assign sout      = sout_bit;
  assign sout_oe   = en && dout_en && !ss_block;
  assign ss_rdy_o  = rdy_q;
  assign ss_rdy_oe = en && rdy_mode;
endmodule

// File: rtl/sio_port_chk.sv
module sio_port_chk #(
  parameter  int N_SRC = 7,
  localparam int SEL_W = $clog2(N_SRC + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             dout_en,
  input logic [SEL_W-1:0] clk_sel,
  input logic [1:0]       fmt,
  input logic             pin_fn_en,
  input logic             rdy_sel,
  input logic             tx_ready,
  input logic             busy,
  input logic             irq,
  input logic             sclk_o,
  input logic             sclk_oe,
  input logic             sout_oe,
  input logic             ss_rdy_oe
);
  localparam logic [SEL_W-1:0] SLV = SEL_W'(N_SRC);

  a_r3_sclk_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy)) |-> (sclk_o == $past(fmt[1])));

  a_r3_sclk_oe: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_oe |-> (en && clk_sel != SLV));

  a_r4_sout_oe: assert property (@(posedge clk) disable iff (!rst_n)
    sout_oe |-> (en && dout_en));

  a_r7_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  a_r7_irq_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (!busy || $past(busy, 2)));

  a_r9_rdy_mode: assert property (@(posedge clk) disable iff (!rst_n)
    ss_rdy_oe |-> (clk_sel == SLV && pin_fn_en && rdy_sel));

  a_r11_ready_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !tx_ready);

  a_r12_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !busy);
endmodule

bind sio_port sio_port_chk #(.N_SRC(N_SRC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en        (en),
  .dout_en   (dout_en),
  .clk_sel   (clk_sel),
  .fmt       (fmt),
  .pin_fn_en (pin_fn_en),
  .rdy_sel   (rdy_sel),
  .tx_ready  (tx_ready),
  .busy      (busy),
  .irq       (irq),
  .sclk_o    (sclk_o),
  .sclk_oe   (sclk_oe),
  .sout_oe   (sout_oe),
  .ss_rdy_oe (ss_rdy_oe)
);

// File: tb/sio_port_test.sv
module sio_port_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int N_SRC = 7;

  logic clk = 0, rst_n = 0;
  logic en = 0, dout_en = 0, trig = 0, lsb_first = 0, pin_fn_en = 0, rdy_sel = 0;
  logic [2:0] clk_sel = 0;
  logic [1:0] fmt = 0;
  logic [N_SRC-1:0] tick_en;
  logic tx_valid = 0, tx_ready;
  logic [W-1:0] tx_data = 0, rx_data;
  logic irq, busy, sclk_i = 0, sclk_o, sclk_oe, sin_r = 0, sout, sout_oe;
  logic ss_n = 1, ss_rdy_o, ss_rdy_oe;

  int cyc = 0;
  int n_chk = 0, n_bad = 0;
  int irq_cnt = 0;
  logic [W-1:0] rx_seen = 0;
  logic busy_seen = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always_comb for (int i = 0; i < N_SRC; i++) tick_en[i] = (cyc % (i + 2)) == 0;

  sio_port #(.W(W), .N_SRC(N_SRC)) uut (
    .clk(clk), .rst_n(rst_n), .en(en), .dout_en(dout_en), .trig(trig),
    .clk_sel(clk_sel), .fmt(fmt), .lsb_first(lsb_first), .pin_fn_en(pin_fn_en),
    .rdy_sel(rdy_sel), .tick_en(tick_en), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .rx_data(rx_data), .irq(irq), .busy(busy), .sclk_i(sclk_i),
    .sclk_o(sclk_o), .sclk_oe(sclk_oe), .sin(sin_r), .sout(sout), .sout_oe(sout_oe),
    .ss_rdy_i(ss_n), .ss_rdy_o(ss_rdy_o), .ss_rdy_oe(ss_rdy_oe)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One negedge step, recording completion pulses.
  task automatic step();
    @(negedge clk);
    if (irq) begin
      irq_cnt++;
      rx_seen = rx_data;
      busy_seen = busy;
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic run_master(input int sel, input int f, input int lsb,
                            input logic [W-1:0] txb, input logic [W-1:0] rxb, input bit poke);
    logic cpol, cpha, prev, ld;
    logic [W-1:0] cap;
    int toggles, k, guard, c0;
    bit poked;
    cpol = f[1]; cpha = f[0]; cap = '0; toggles = 0; k = 0; guard = 0; poked = 0;
    clk_sel = 3'(sel); fmt = 2'(f); lsb_first = lsb[0]; pin_fn_en = 0;
    wait_n(2);
    check(sclk_o == cpol, "R3 idle level", 32'(sclk_o), 32'(cpol));
    tx_valid = 1; tx_data = txb; step(); tx_valid = 0;
    sin_r = lsb[0] ? rxb[0] : rxb[W-1];
    c0 = irq_cnt;
    trig = 1; prev = sclk_o; step(); trig = 0;
    check(busy && !tx_ready, "R11 busy blocks load", {busy, tx_ready}, 2'b10);
    while (irq_cnt == c0 && guard < 4000) begin
      tx_valid = poke && k == 2 && !poked;
      if (tx_valid) begin tx_data = ~txb; poked = 1; end
      step();
      tx_valid = 0;
      guard++;
      if (sclk_o != prev) begin
        toggles++;
        ld = (sclk_o != cpol);
        if (ld != cpha && k < W) begin
          if (lsb[0]) cap[k] = sout; else cap[W-1-k] = sout;
          k++;
          if (k < W) sin_r = lsb[0] ? rxb[k] : rxb[W-1-k];
        end
        prev = sclk_o;
      end
    end
    check(irq_cnt == c0 + 1, "R7 irq seen", 32'(irq_cnt - c0), 1);
    check(toggles == 2 * W, "R2 toggle count", 32'(toggles), 32'(2 * W));
    check(cap == txb, "R5 R6 transmitted byte", 32'(cap), 32'(txb));
    check(rx_seen == rxb, "R6 received byte", 32'(rx_seen), 32'(rxb));
    check(!busy_seen, "R7 busy low at irq", 32'(busy_seen), 0);
    step();
    check(!irq && sclk_o == cpol, "R7 R3 irq pulse and idle", {irq, sclk_o}, {1'b0, cpol});
  endtask

  task automatic run_slave(input int f, input int lsb, input logic [W-1:0] txb,
                           input logic [W-1:0] rxb, input int mode);
    logic cpol, cpha, ld;
    logic [W-1:0] cap;
    int k, c0;
    cpol = f[1]; cpha = f[0]; cap = '0; k = 0;
    clk_sel = 3'd7; fmt = 2'(f); lsb_first = lsb[0];
    pin_fn_en = (mode != 0); rdy_sel = (mode == 1); ss_n = (mode == 2);
    sclk_i = cpol;
    wait_n(5);
    tx_valid = 1; tx_data = txb; step(); tx_valid = 0;
    c0 = irq_cnt;
    trig = 1; step(); trig = 0; step();
    if (mode == 1)
      check(ss_rdy_oe && ss_rdy_o, "R9 ready after trigger", {ss_rdy_oe, ss_rdy_o}, 2'b11);
    else
      check(!ss_rdy_oe, "R9 ready pin off", 32'(ss_rdy_oe), 0);
    if (mode == 2) begin
      check(!sout_oe, "R10 sout off while deselected", 32'(sout_oe), 0);
      for (int e = 0; e < 6; e++) begin sclk_i = ~sclk_i; wait_n(8); end
      check(busy && irq_cnt == c0, "R10 edges ignored", {busy, 1'(irq_cnt - c0)}, 2'b10);
      ss_n = 0; wait_n(5);
      check(sout_oe, "R10 sout on when selected", 32'(sout_oe), 1);
    end
    for (int e = 0; e < 2 * W; e++) begin
      ld = (e % 2) == 0;
      if (ld != cpha) begin
        sin_r = lsb[0] ? rxb[k] : rxb[W-1-k];
        if (lsb[0]) cap[k] = sout; else cap[W-1-k] = sout;
        k++;
      end
      sclk_i = ~sclk_i;
      wait_n(8);
      if (mode == 1 && e == 0)
        check(!ss_rdy_o, "R9 ready falls on first edge", 32'(ss_rdy_o), 0);
    end
    wait_n(4);
    check(irq_cnt == c0 + 1, "R8 R7 slave completion", 32'(irq_cnt - c0), 1);
    check(cap == txb, "R8 R5 slave transmitted byte", 32'(cap), 32'(txb));
    check(rx_seen == rxb, "R8 R6 slave received byte", 32'(rx_seen), 32'(rxb));
    check(!busy, "R8 slave idle", 32'(busy), 0);
    ss_n = 1;
  endtask

  initial begin
    logic [W-1:0] tb, rb;
    wait_n(3);
    rst_n = 1;
    step();
    check(!busy && !irq && !sclk_oe && !sout_oe && !ss_rdy_oe && tx_ready,
          "R1 reset outputs", {busy, irq, sclk_oe, sout_oe, ss_rdy_oe, tx_ready}, 6'b000001);
    check(rx_data == 0, "R1 reset rx_data", 32'(rx_data), 0);

    // R12: trigger while disabled
    trig = 1; step(); trig = 0; step();
    check(!busy && !sclk_oe, "R12 trigger ignored when off", {busy, sclk_oe}, 2'b00);

    en = 1; step();
    check(sclk_oe && !sout_oe, "R3 R4 enables without dout_en", {sclk_oe, sout_oe}, 2'b10);
    dout_en = 1; step();
    check(sout_oe, "R4 sout enable", 32'(sout_oe), 1);

    for (int s = 0; s < N_SRC; s++)
      for (int f = 0; f < 4; f++)
        for (int l = 0; l < 2; l++) begin
          tb = W'(8'h5A ^ (s * 37 + f * 11 + l * 3));
          rb = W'(8'hC3 ^ (s * 19 + f * 7 + l * 5));
          run_master(s, f, l, tb, rb, (s + f + l) % 3 == 0);
          run_master(s, f, l, ~rb, tb, 0);
        end

    for (int f = 0; f < 4; f++)
      for (int l = 0; l < 2; l++)
        for (int m = 0; m < 3; m++)
          run_slave(f, l, W'(8'h96 ^ (f * 29 + l * 13 + m)), W'(8'h1E ^ (f * 41 + m * 3 + l)), m);

    // R12: dropping enable aborts an armed slave transfer
    clk_sel = 3'd7; pin_fn_en = 0; step();
    trig = 1; step(); trig = 0; step();
    check(busy, "R12 armed", 32'(busy), 1);
    en = 0; step();
    check(!busy && !sout_oe, "R12 abort on disable", {busy, sout_oe}, 2'b00);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule